// File: doc/BRIEF.md
# SDIO Function 1 Interrupt and Mailbox Register Bank

This block sits on the slave side of an SDIO link, behind the function 1 register path. The host reaches it with single-byte accesses: an address, a write strobe, write data and read data that follows the address combinationally. It holds three groups of registers.

The first group covers eight slave-to-host interrupt sources. It has a pending-status byte, a mask byte and a write-one-to-clear byte. While any unmasked source is pending, the block pulls an active-low interrupt level onto DAT1. The second group is a doorbell byte. A host write to it hands the written bits to slave logic as a one-cycle pulse, and the stored byte then clears itself. The third group is a window of twelve shared byte registers. Both the host and local slave logic can read and write them.

A separate slave-side port lets local logic raise interrupt sources, access the shared registers by index and receive doorbell pulses.

Top module: `sdio_mbx_top`

## Requirements
- R1: After reset the status, mask, doorbell and all shared registers are zero, `dat1_n` is high and `slv_db_pulse` is zero.
- R2: A 1 on bit i of `slv_irq_set` in one cycle makes bit i of the status byte (host offset 0x058) read 1 from the next cycle on, until it is cleared. Bits at or above the source count read 0.
- R3: The mask byte at offset 0x0DC is written by the host and reads back the written value. A 1 enables the matching source.
- R4: A host write to the clear offset 0x0D4 clears every status bit written as 1 and leaves bits written as 0 unchanged. The clear offset always reads 0. If a source is set in the same cycle it is cleared, the bit stays 1.
- R5: `dat1_n` is low in exactly the cycles in which some status bit and its mask bit are both 1, and high otherwise.
- R6: A host write of byte D to offset 0x08D makes `slv_db_pulse` equal D for exactly the next cycle, then 0 unless written again. Offset 0x08D reads the pending doorbell byte while it is presented.
- R7: The host reads and writes shared register k at offset 0x06C+k for k from 0 to 11. The slave reads and writes the same register at `slv_sh_idx`=k. A write by either side is visible to both from the next cycle.
- R8: When host and slave write the same shared register in the same cycle, the host data is stored.
- R9: Host reads of unmapped offsets return 0, and host writes to them change no register. The status offset is read-only to the host. Slave accesses with an index of 12 or more read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 12 | Host register byte offset |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte for `hst_addr` |
| dat1_n | output | 1 | Active-low level interrupt to the host |
| slv_irq_set | input | 8 | Per-source set pulses from slave logic |
| slv_sh_wr | input | 1 | Slave shared-register write strobe |
| slv_sh_idx | input | 4 | Slave shared-register index |
| slv_sh_wdata | input | 8 | Slave shared-register write byte |
| slv_sh_rdata | output | 8 | Shared register selected by `slv_sh_idx` |
| slv_db_pulse | output | 8 | Doorbell bits, valid for one cycle |

## Verification
A wrong status or mask bit shows on `dat1_n` in the cycle after the event that corrupted it. It also shows on `hst_rdata` as soon as the status or mask offset is addressed. A doorbell byte that fails to clear shows as a pulse on `slv_db_pulse` lasting two cycles or more. A corrupted shared byte appears on both read paths at once. Because the model is compared on every clock, each fault is caught in the first cycle it reaches a port.

// File: rtl/sdio_mbx_pkg.sv
package sdio_mbx_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 12;

   localparam logic [ADDR_W-1:0] OFS_STATUS   = 12'h058;
   localparam logic [ADDR_W-1:0] OFS_SHARED   = 12'h06C;
   localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h08D;
   localparam logic [ADDR_W-1:0] OFS_CLEAR    = 12'h0D4;
   localparam logic [ADDR_W-1:0] OFS_ENABLE   = 12'h0DC;

   typedef struct packed {
      logic              wr;
      logic [DATA_W-1:0] data;
   } byte_wr_t;
endpackage

// File: rtl/sdio_mbx_irq_bank.sv
module sdio_mbx_irq_bank #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic             clr_wr_i,
   input  logic             en_wr_i,
   input  logic [N_SRC-1:0] wdata_i,
   output logic [N_SRC-1:0] status_o,
   output logic [N_SRC-1:0] enable_o
);
   logic [N_SRC-1:0] st_q;
   logic [N_SRC-1:0] en_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic clr_hit;
      assign clr_hit = clr_wr_i & wdata_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q[i] <= 1'b0;
         else        st_q[i] <= set_i[i] | (st_q[i] & ~clr_hit);
      end

      assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> status_o[i]);
      assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit && !set_i[i]) |=> !status_o[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[i] && !clr_wr_i) |=> status_o[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_wr_i) en_q <= wdata_i;
   end

   assign status_o = st_q;
   assign enable_o = en_q;
endmodule

// File: rtl/sdio_mbx_doorbell.sv
module sdio_mbx_doorbell #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] pend_o
);
   logic [W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q <= '0;
      else if (wr_i) pend_q <= wdata_i;
      else           pend_q <= '0;
   end

   assign pend_o = pend_q;

   assert_db_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> (pend_o == '0));
   assert_db_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (pend_o == $past(wdata_i)));
endmodule

// File: rtl/sdio_mbx_shared.sv
module sdio_mbx_shared #(
   parameter int N     = 12,
   parameter int IDX_W = 4,
   parameter int W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr_i,
   input  logic [IDX_W-1:0]    host_idx_i,
   input  logic [W-1:0]        host_wdata_i,
   input  logic                slv_wr_i,
   input  logic [IDX_W-1:0]    slv_idx_i,
   input  logic [W-1:0]        slv_wdata_i,
   output logic [N-1:0][W-1:0] regs_o
);
   for (genvar k = 0; k < N; k++) begin : g_reg
      logic         h_hit, s_hit;
      logic [W-1:0] r_q;

      assign h_hit = host_wr_i && (host_idx_i == IDX_W'(k));
      assign s_hit = slv_wr_i && (slv_idx_i == IDX_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     r_q <= '0;
         else if (h_hit) r_q <= host_wdata_i;
         else if (s_hit) r_q <= slv_wdata_i;
      end

      assign regs_o[k] = r_q;

      assert_host_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr_i && slv_wr_i && host_idx_i == IDX_W'(k) && slv_idx_i == IDX_W'(k))
         |=> (regs_o[k] == $past(host_wdata_i)));
      assert_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!(host_wr_i && host_idx_i == IDX_W'(k)) && !(slv_wr_i && slv_idx_i == IDX_W'(k)))
         |=> $stable(regs_o[k]));
   end
endmodule

// File: rtl/sdio_mbx_top.sv
module sdio_mbx_top
   import sdio_mbx_pkg::*;
#(
   parameter int N_SRC       = 8,
   parameter int N_SHARED    = 12,
   parameter bit DB_READBACK = 1'b1,
   localparam int IDX_W      = (N_SHARED > 1) ? $clog2(N_SHARED + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic              hst_wr,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata,
   output logic              dat1_n,
   input  logic [N_SRC-1:0]  slv_irq_set,
   input  logic              slv_sh_wr,
   input  logic [IDX_W-1:0]  slv_sh_idx,
   input  logic [DATA_W-1:0] slv_sh_wdata,
   output logic [DATA_W-1:0] slv_sh_rdata,
   output logic [DATA_W-1:0] slv_db_pulse
);
   if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_src
      $error("N_SRC must lie between 1 and the byte width");
   end
   if (N_SHARED < 1 || int'(OFS_SHARED) + N_SHARED > int'(OFS_DOORBELL)) begin : g_bad_sh
      $error("shared window must be non-empty and end below the doorbell offset");
   end

   logic [ADDR_W-1:0] sh_diff;
   logic              sh_hit;
   logic [IDX_W-1:0]  sh_off;
   byte_wr_t          clr_w, en_w, db_w;
   logic [N_SRC-1:0]  status, enable;
   logic [DATA_W-1:0] db_pend, db_rd;
   logic [N_SHARED-1:0][DATA_W-1:0] sh_regs;

   assign sh_diff = hst_addr - OFS_SHARED;
   assign sh_hit  = sh_diff < ADDR_W'(N_SHARED);
   assign sh_off  = IDX_W'(sh_diff);

   assign clr_w = '{wr: hst_wr && hst_addr == OFS_CLEAR,    data: hst_wdata};
   assign en_w  = '{wr: hst_wr && hst_addr == OFS_ENABLE,   data: hst_wdata};
   assign db_w  = '{wr: hst_wr && hst_addr == OFS_DOORBELL, data: hst_wdata};

   sdio_mbx_irq_bank #(.N_SRC(N_SRC)) irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (slv_irq_set),
      .clr_wr_i (clr_w.wr),
      .en_wr_i  (en_w.wr),
      .wdata_i  (hst_wdata[N_SRC-1:0]),
      .status_o (status),
      .enable_o (enable)
   );

   sdio_mbx_doorbell #(.W(DATA_W)) db_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (db_w.wr),
      .wdata_i (db_w.data),
      .pend_o  (db_pend)
   );

   sdio_mbx_shared #(.N(N_SHARED), .IDX_W(IDX_W), .W(DATA_W)) sh_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_wr_i    (hst_wr && sh_hit),
      .host_idx_i   (sh_off),
      .host_wdata_i (hst_wdata),
      .slv_wr_i     (slv_sh_wr),
      .slv_idx_i    (slv_sh_idx),
      .slv_wdata_i  (slv_sh_wdata),
      .regs_o       (sh_regs)
   );

   if (DB_READBACK) begin : g_db_rd
      assign db_rd = db_pend;
   end else begin : g_db_zero
      assign db_rd = '0;
   end

   always_comb begin
      hst_rdata = '0;
      if (hst_addr == OFS_STATUS)        hst_rdata = DATA_W'(status);
      else if (hst_addr == OFS_ENABLE)   hst_rdata = DATA_W'(enable);
      else if (hst_addr == OFS_DOORBELL) hst_rdata = db_rd;
      else if (sh_hit) begin
         for (int k = 0; k < N_SHARED; k++)
            if (sh_off == IDX_W'(k)) hst_rdata = sh_regs[k];
      end
   end

   always_comb begin
      slv_sh_rdata = '0;
      for (int k = 0; k < N_SHARED; k++)
         if (slv_sh_idx == IDX_W'(k)) slv_sh_rdata = sh_regs[k];
   end

   assign dat1_n       = ~|(status & enable);
   assign slv_db_pulse = db_pend;

   assert_dat1_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_irq_set == '0 && !clr_w.wr && !en_w.wr) |=> $stable(dat1_n));
   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_hit && hst_addr != OFS_STATUS && hst_addr != OFS_ENABLE
       && hst_addr != OFS_DOORBELL) |-> (hst_rdata == '0));
   assert_clear_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_addr == OFS_CLEAR) |-> (hst_rdata == '0));
endmodule

// File: tb/sdio_mbx_top_tb_top.sv
module sdio_mbx_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] hst_addr = '0;
   logic        hst_wr = 1'b0;
   logic [7:0]  hst_wdata = '0;
   logic [7:0]  hst_rdata;
   logic        dat1_n;
   logic [7:0]  slv_irq_set = '0;
   logic        slv_sh_wr = 1'b0;
   logic [3:0]  slv_sh_idx = '0;
   logic [7:0]  slv_sh_wdata = '0;
   logic [7:0]  slv_sh_rdata;
   logic [7:0]  slv_db_pulse;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   int m_st = 0, m_en = 0, m_db = 0;
   int m_sh [12];

   always #10 clk = ~clk;

   sdio_mbx_top dut_i (
      .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dat1_n(dat1_n),
      .slv_irq_set(slv_irq_set), .slv_sh_wr(slv_sh_wr), .slv_sh_idx(slv_sh_idx),
      .slv_sh_wdata(slv_sh_wdata), .slv_sh_rdata(slv_sh_rdata),
      .slv_db_pulse(slv_db_pulse)
   );

   function automatic int exp_read(int a);
      if (a == 'h058) return m_st;
      if (a == 'h0DC) return m_en;
      if (a == 'h08D) return m_db;
      if (a >= 'h06C && a <= 'h077) return m_sh[a - 'h06C];
      return 0;
   endfunction

   task automatic model_update();
      int clr = (hst_wr && hst_addr == 12'h0D4) ? int'(hst_wdata) : 0;
      m_st = ((m_st & ~clr) | int'(slv_irq_set)) & 'hFF;
      if (hst_wr && hst_addr == 12'h0DC) m_en = int'(hst_wdata);
      m_db = (hst_wr && hst_addr == 12'h08D) ? int'(hst_wdata) : 0;
      if (slv_sh_wr && slv_sh_idx < 12) m_sh[slv_sh_idx] = int'(slv_sh_wdata);
      if (hst_wr && hst_addr >= 12'h06C && hst_addr <= 12'h077)
         m_sh[hst_addr - 12'h06C] = int'(hst_wdata);
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      int ex_sl = (slv_sh_idx < 12) ? m_sh[slv_sh_idx] : 0;
      chk(tag, "hst_rdata", int'(hst_rdata), exp_read(int'(hst_addr)));
      chk(tag, "slv_sh_rdata", int'(slv_sh_rdata), ex_sl);
      chk(tag, "slv_db_pulse", int'(slv_db_pulse), m_db);
      chk(tag, "dat1_n", int'(dat1_n), ((m_st & m_en) == 0) ? 1 : 0);
   endtask

   // one clock: inputs already driven at a falling edge
   task automatic step(string tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle();
      hst_wr = 1'b0; slv_irq_set = '0; slv_sh_wr = 1'b0;
   endtask

   task automatic hwrite(string tag, int a, int d);
      idle(); hst_addr = 12'(a); hst_wr = 1'b1; hst_wdata = 8'(d);
      step(tag);
      idle();
   endtask

   task automatic hread(string tag, int a);
      idle(); hst_addr = 12'(a);
      step(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      foreach (m_sh[k]) m_sh[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state over every mapped offset
      hread("R1", 'h058); hread("R1", 'h0DC); hread("R1", 'h08D);
      for (int k = 0; k < 12; k++) begin
         slv_sh_idx = 4'(k);
         hread("R1", 'h06C + k);
      end
      // R2 slave raises sources
      idle(); hst_addr = 12'h058; slv_irq_set = 8'h05; step("R2");
      idle(); step("R2");
      slv_irq_set = 8'h80; step("R2"); idle(); step("R2");
      // R3/R5 mask and DAT1 level
      hwrite("R3", 'h0DC, 'h04); hread("R3", 'h0DC);
      hread("R5", 'h058);
      hwrite("R5", 'h0DC, 'h02); hread("R5", 'h0DC);
      hwrite("R5", 'h0DC, 'h85); hread("R5", 'h058);
      // R4 clear
      hwrite("R4", 'h0D4, 'h01); hread("R4", 'h0D4); hread("R4", 'h058);
      idle(); hst_addr = 12'h0D4; hst_wr = 1'b1; hst_wdata = 8'h84; slv_irq_set = 8'h80;
      step("R4"); idle(); hread("R4", 'h058);
      hwrite("R4", 'h0D4, 'hFF); hread("R5", 'h058);
      // R6 doorbell
      idle(); hst_addr = 12'h08D; hst_wr = 1'b1; hst_wdata = 8'hA5; step("R6");
      idle(); step("R6"); step("R6");
      hst_wr = 1'b1; hst_wdata = 8'h01; step("R6");
      hst_wdata = 8'h80; step("R6");
      idle(); step("R6");
      // R7 shared window from both sides
      for (int k = 0; k < 12; k++) hwrite("R7", 'h06C + k, k * 17 + 3);
      for (int k = 0; k < 12; k++) begin
         slv_sh_idx = 4'(k); hread("R7", 'h06C + k);
      end
      for (int k = 0; k < 12; k++) begin
         idle(); slv_sh_wr = 1'b1; slv_sh_idx = 4'(k); slv_sh_wdata = 8'(255 - k);
         hst_addr = 12'(12'h06C + k); step("R7");
         idle(); step("R7");
      end
      // R8 same-cycle conflict
      idle(); hst_addr = 12'h071; hst_wr = 1'b1; hst_wdata = 8'h3C;
      slv_sh_wr = 1'b1; slv_sh_idx = 4'd5; slv_sh_wdata = 8'hC3;
      step("R8"); idle(); step("R8");
      // R9 unmapped and read-only
      slv_sh_wr = 1'b1; slv_sh_idx = 4'd12; slv_sh_wdata = 8'hEE; step("R9");
      slv_sh_idx = 4'd15; step("R9"); idle(); step("R9");
      idle(); slv_irq_set = 8'h20; step("R9"); idle();
      hwrite("R9", 'h058, 'h00); hread("R9", 'h058);
      hwrite("R9", 'h06B, 'hAA); hwrite("R9", 'h078, 'hAA);
      hwrite("R9", 'h059, 'hAA); hwrite("R9", 'h0FF, 'hAA);
      hread("R9", 'h06B); hread("R9", 'h078); hread("R9", 'h0D5);
      for (int k = 0; k < 12; k++) begin
         slv_sh_idx = 4'(k); hread("R9", 'h06C + k);
      end
      hread("R9", 'h0DC); hread("R9", 'h08D);
      // mixed traffic
      begin
         logic [15:0] lfsr = 16'hACE1;
         for (int n = 0; n < 400; n++) begin
            int sel;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = int'(lfsr[3:0]);
            idle();
            case (sel % 6)
               0: hst_addr = 12'h058;
               1: hst_addr = 12'h0DC;
               2: hst_addr = 12'h0D4;
               3: hst_addr = 12'h08D;
               4: hst_addr = 12'(12'h06C + (int'(lfsr[7:4]) % 12));
               default: hst_addr = 12'(lfsr[11:4]);
            endcase
            hst_wr = lfsr[8];
            hst_wdata = lfsr[15:8];
            slv_irq_set = lfsr[12] ? 8'(1 << lfsr[6:4]) : 8'h00;
            slv_sh_wr = lfsr[9];
            slv_sh_idx = lfsr[13:10];
            slv_sh_wdata = lfsr[7:0];
            step("MIX");
         end
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule